// File: doc/BRIEF.md
# Scan-Rate Decimating Sample Gate

This block sits between the output of a sample FIFO and whatever consumes the samples. The converter runs scans back to back at one pacer rate. The wanted scan period, however, is a whole multiple of one scan. The gate therefore treats the incoming stream as repeating chunks of `L x (1+D)` samples, where `L` is the scan length in channels and `D` is the number of scans to skip. It passes the first `L` samples of each chunk and silently consumes the rest. The chunk position carries over across gaps in the input, so scan alignment does not depend on how the upstream side splits the data into bursts.

Software sets `D` once, as the requested scan period divided by `L` times the convert period, minus one. A period shorter than one scan counts as exactly one scan, and any other period is rounded down to a whole number of scans.

A start pulse captures `L`, `D`, the number of scans and the unlimited flag, and clears the chunk position. In finite mode the gate consumes exactly `scans x L x (1+D)` input samples, dropped ones included. It then raises `done` and refuses further input until the next start. Because of this, a burst request near the end only pulls what remains of the budget. In unlimited mode the budget is not used and `done` stays low.

Both streams are valid/ready:
- A transfer happens on any cycle where valid and ready are both high.
- Input ready never depends on input valid.
- Once output valid is high, it and its data hold until the consumer accepts them.
- A sample that is due to be dropped is accepted whatever the output side is doing.

Top module: `scan_decim_gate`

## Requirements
- R1: After reset, `in_ready`, `out_valid` and `done` are all 0, and no input is taken until a start pulse arrives.
- R2: A start pulse captures the settings and clears both the chunk position and `done`. `in_ready` is 0 during the start cycle. A scan length of 0 is treated as 1.
- R3: Number the consumed input samples k = 0, 1, 2, … from start. Sample k is forwarded, in order and unchanged, when k mod (L x (1+D)) < L. Every other sample is consumed and discarded.
- R4: The chunk position only advances on accepted input samples. Cycles with `in_valid` low and cycles of output back-pressure leave the forwarded sequence of R3 unchanged.
- R5: When D = 0, every consumed sample is forwarded.
- R6: In finite mode exactly scans x L x (1+D) samples are consumed. `done` rises in the cycle after the last of them is accepted.
- R7: While `done` is high, `in_ready` is 0 and `done` stays high until the next start pulse.
- R8: In unlimited mode `done` never asserts and input keeps flowing.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. In that state a sample due to be forwarded is refused, and a sample due to be dropped is accepted.
- R10: A finite start with 0 scans raises `done` in the next cycle without consuming any input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse: capture settings and begin an acquisition |
| cfg_scan_len | input | LEN_W | Channels per scan (L); 0 counts as 1 |
| cfg_skip | input | SKIP_W | Scans skipped after each kept scan (D) |
| cfg_scans | input | SCAN_W | Kept scans to collect in finite mode |
| cfg_unlimited | input | 1 | 1: run without a budget |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Gate accepts the input sample |
| in_data | input | DATA_W | Input sample |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Consumer accepts the output sample |
| out_data | output | DATA_W | Output sample |
| done | output | 1 | Finite budget exhausted |

## Verification
The bench sweeps scan lengths 0 to 3, skip counts 0 to 2 and scan counts 1 and 2 under four handshake patterns:
- a steady stream, which checks the basic keep/drop arithmetic;
- input gaps only, which would expose a position counter that advances on idle cycles;
- output stalls only, which separates dropped samples (still accepted) from kept ones (held back);
- both kinds of irregularity together, which checks that scan alignment survives the combination.

Each input carries its own index as data, so any misplaced sample is visible as a wrong value. Further runs cover unlimited mode, zero scans, and the state after `done`.

// File: rtl/sgate_pkg.sv
package sgate_pkg;
  typedef enum logic [1:0] {
    SG_IDLE = 2'd0,
    SG_RUN  = 2'd1,
    SG_DONE = 2'd2
  } sg_state_e;
endpackage

// File: rtl/sgate_chunk_pos.sv
module sgate_chunk_pos #(
  parameter int LEN_W   = 5,
  parameter int CHUNK_W = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [LEN_W-1:0]   load_len,
  input  logic [CHUNK_W-1:0] load_chunk,
  input  logic               load_skip_zero,
  input  logic               step,
  output logic               keep
);
  logic [LEN_W-1:0]   len_q;
  logic [CHUNK_W-1:0] chunk_q;
  logic               skip_zero_q;
  logic [CHUNK_W-1:0] pos;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q       <= LEN_W'(1);
      chunk_q     <= CHUNK_W'(1);
      skip_zero_q <= 1'b1;
      pos         <= '0;
    end else if (load) begin
      len_q       <= load_len;
      chunk_q     <= load_chunk;
      skip_zero_q <= load_skip_zero;
      pos         <= '0;
    end else if (step && !skip_zero_q) begin
      if (pos == chunk_q - CHUNK_W'(1)) pos <= '0;
      else                              pos <= pos + CHUNK_W'(1);
    end
  end

  assign keep = skip_zero_q || (pos < CHUNK_W'(len_q));

  // R3: position stays inside the chunk
  p_pos_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !skip_zero_q |-> pos < chunk_q);
  // R5: with no skipping the position never moves
  p_pos_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_zero_q && !load) |=> pos == $past(pos));
endmodule

// File: rtl/sgate_budget.sv
module sgate_budget #(
  parameter int BUD_W = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BUD_W-1:0] load_count,
  input  logic             load_unlimited,
  input  logic             step,
  output logic             last,
  output logic             unlimited
);
  logic [BUD_W-1:0] cnt;
  logic             unl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      unl_q <= 1'b0;
    end else if (load) begin
      cnt   <= load_unlimited ? '0 : load_count;
      unl_q <= load_unlimited;
    end else if (step && !unl_q) begin
      cnt <= cnt - BUD_W'(1);
    end
  end

  assign last      = !unl_q && (cnt == BUD_W'(1));
  assign unlimited = unl_q;

  // R6: a finite budget is never consumed past zero
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !unl_q && !load) |-> cnt != '0);
endmodule

// File: rtl/sgate_out_stage.sv
module sgate_out_stage #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  output logic              space,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (push) begin
      out_valid <= 1'b1;
      out_data  <= push_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign space = !out_valid || out_ready;

  // R9: a stalled output holds valid and data
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/scan_decim_gate.sv
module scan_decim_gate #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 5,
  parameter int SKIP_W = 8,
  parameter int SCAN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  cfg_scan_len,
  input  logic [SKIP_W-1:0] cfg_skip,
  input  logic [SCAN_W-1:0] cfg_scans,
  input  logic              cfg_unlimited,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              done
);
  import sgate_pkg::*;

  localparam int CHUNK_W = LEN_W + SKIP_W + 1;
  localparam int BUD_W   = SCAN_W + CHUNK_W;

  sg_state_e          state;
  logic [LEN_W-1:0]   len_eff;
  logic [CHUNK_W-1:0] chunk_len;
  logic [BUD_W-1:0]   budget_init;
  logic               keep, space, last, unl_q, fire;

  assign len_eff     = (cfg_scan_len == '0) ? LEN_W'(1) : cfg_scan_len;
  assign chunk_len   = CHUNK_W'(len_eff) * (CHUNK_W'(cfg_skip) + CHUNK_W'(1));
  assign budget_init = BUD_W'(cfg_scans) * BUD_W'(chunk_len);

  assign in_ready = (state == SG_RUN) && !start && (!keep || space);
  assign fire     = in_valid && in_ready;
  assign done     = (state == SG_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SG_IDLE;
    end else if (start) begin
      state <= (!cfg_unlimited && budget_init == '0) ? SG_DONE : SG_RUN;
    end else if (fire && last) begin
      state <= SG_DONE;
    end
  end

  sgate_chunk_pos #(.LEN_W(LEN_W), .CHUNK_W(CHUNK_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .load(start), .load_len(len_eff),
    .load_chunk(chunk_len), .load_skip_zero(cfg_skip == '0),
    .step(fire), .keep(keep)
  );

  sgate_budget #(.BUD_W(BUD_W)) u_budget (
    .clk(clk), .rst_n(rst_n), .load(start), .load_count(budget_init),
    .load_unlimited(cfg_unlimited), .step(fire), .last(last),
    .unlimited(unl_q)
  );

  sgate_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .push(fire && keep), .push_data(in_data),
    .space(space), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  // R7: no input taken once the budget is spent
  p_no_accept_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);
  // R7: done stays until a new start
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
  // R8: unlimited runs never finish
  p_unl_no_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (unl_q && !start) |=> !done);
  // R2: a start with a nonzero budget rearms the gate
  p_start_rearm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (cfg_unlimited || budget_init != '0)) |=> !done);
endmodule

// File: tb/scan_decim_gate_tb.sv
module scan_decim_gate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  cfg_scan_len = '0;
  logic [7:0]  cfg_skip = '0;
  logic [15:0] cfg_scans = '0;
  logic        cfg_unlimited = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;
  logic        done;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  scan_decim_gate u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_scan_len(cfg_scan_len),
    .cfg_skip(cfg_skip), .cfg_scans(cfg_scans), .cfg_unlimited(cfg_unlimited),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit keep_k(input int k, input int le, input int d);
    return (d == 0) || ((k % (le * (1 + d))) < le);
  endfunction

  function automatic bit pat_valid(input int pat, input int c);
    case (pat)
      1: return (c % 3) != 1;
      3: return (c % 5) != 2;
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit pat_ready(input int pat, input int c);
    case (pat)
      2: return (c % 4) < 2;
      3: return (c % 3) != 0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic do_start(input int l, input int d, input int s, input bit unl);
    @(negedge clk);
    cfg_scan_len = 5'(l); cfg_skip = 8'(d); cfg_scans = 16'(s);
    cfg_unlimited = unl; start = 1'b1; in_valid = 1'b1; out_ready = 1'b1;
    #1;
    chk(!in_ready, "R2 in_ready during start", int'(in_ready), 0);
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0;
  endtask

  task automatic run_case(input int l, input int d, input int s, input bit unl, input int pat);
    int le, budget, k, e, nfwd;
    bit hold;
    logic [15:0] hold_val;
    le = (l == 0) ? 1 : l;
    budget = s * le * (1 + d);
    k = 0; e = 0; nfwd = 0; hold = 0; hold_val = '0;
    do_start(l, d, s, unl);
    for (int c = 0; c < 2000; c++) begin
      bit drain;
      drain = unl && (c >= 120);
      if (!unl && done && !out_valid) break;
      if (drain && !out_valid) break;
      in_valid = drain ? 1'b0 : pat_valid(pat, c);
      out_ready = drain ? 1'b1 : pat_ready(pat, c);
      in_data = 16'(k);
      #1;
      if (hold)
        chk(out_valid && out_data == hold_val, "R9 hold", int'(out_data), int'(hold_val));
      hold = out_valid && !out_ready;
      hold_val = out_data;
      if (unl) chk(!done, "R8 done in unlimited", int'(done), 0);
      if (!done && out_valid && !out_ready && in_valid) begin
        if (keep_k(k, le, d)) chk(!in_ready, "R9 kept sample refused", int'(in_ready), 0);
        else                  chk(in_ready, "R9 dropped sample accepted", int'(in_ready), 1);
      end
      if (out_valid && out_ready) begin
        while (!keep_k(e, le, d)) e++;
        if (d == 0)        chk(out_data == 16'(e), "R5 forward all", int'(out_data), e);
        else if (pat != 0) chk(out_data == 16'(e), "R4 alignment", int'(out_data), e);
        else               chk(out_data == 16'(e), "R3 keep/drop", int'(out_data), e);
        e++; nfwd++;
      end
      if (in_valid && in_ready) begin
        k++;
        if (!unl && k > budget) chk(1'b0, "R6 over budget", k, budget);
      end
      @(negedge clk);
    end
    in_valid = 1'b0; out_ready = 1'b1;
    if (!unl) begin
      chk(done, "R6 done raised", int'(done), 1);
      chk(k == budget, "R6 consumed count", k, budget);
      chk(nfwd == s * le, "R3 forwarded count", nfwd, s * le);
      in_valid = 1'b1;
      for (int i = 0; i < 3; i++) begin
        @(negedge clk); #1;
        chk(!in_ready && done, "R7 locked after done", int'(in_ready), 0);
      end
      in_valid = 1'b0;
    end else begin
      chk(nfwd > 0 && !done, "R8 unlimited flowing", nfwd, 1);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    in_valid = 1'b1;
    #1;
    // R1: idle after reset, nothing taken
    chk(!in_ready && !out_valid && !done, "R1 reset state",
        int'({in_ready, out_valid, done}), 0);
    @(negedge clk); #1;
    chk(!in_ready, "R1 no accept before start", int'(in_ready), 0);
    in_valid = 1'b0;

    for (int pat = 0; pat < 4; pat++)
      for (int l = 0; l < 4; l++)
        for (int d = 0; d < 3; d++)
          for (int s = 1; s < 3; s++)
            run_case(l, d, s, 1'b0, pat);

    run_case(3, 2, 0, 1'b1, 3);
    run_case(2, 0, 0, 1'b1, 1);

    // R10: zero scans finishes at once
    do_start(2, 1, 0, 1'b0);
    in_valid = 1'b1; #1;
    chk(done && !in_ready, "R10 zero scans", int'(done), 1);
    in_valid = 1'b0;

    // R2: a new start clears done and rearms
    run_case(2, 1, 1, 1'b0, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule